// File: doc/BRIEF.md
# Message Time-Tag Counter

This block keeps the 16-bit time value that a 1553 terminal stamps on every message it handles. The protocol logic reads `tag_value` whenever it closes out a message and copies it into the time word of that message's descriptor entry. The host can write a new value at any time. The counter can advance from one of three sources:
- an internal time base, divided down from the system clock to a resolution between 2 µs and 64 µs per count;
- an external clock pin, synchronized into the system clock domain;
- a software step strobe, used for self-test.

The protocol logic reports two kinds of Synchronize mode command:
- a Synchronize without data, which can clear the counter;
- a Synchronize with data, which can load the counter from the received data word.

Each action has its own enable. When the counter wraps from FFFF to 0000 on an increment, the block emits a one-cycle `rollover` pulse for the interrupt logic.

A small source-selection state machine turns the 3-bit `res_sel` code into one of three states:
- `SRC_TIMER`: codes 0 to 5, internal time base;
- `SRC_EXTERN`: code 6, external clock;
- `SRC_STROBE`: code 7, software step.

On every clock the machine moves to the state that the current code names. The move to any state can come from any state, and it takes effect one cycle after the code changes. Any change of code also restarts the internal time base from zero.

Top module: `time_tag_counter`

## Requirements
- R1: While `rst_n` is low and right after it is released, `tag_value` is 0000 and `rollover` is 0.
- R2: With `res_sel` = k for k from 0 to 5, the counter advances by one every CLK_PER_US × 2^(k+1) clock cycles. That gives 2, 4, 8, 16, 32 and 64 µs per count.
- R3: With `res_sel` = 6, the counter advances once for each rising edge of `ext_clk`. The edge passes through a two-flop synchronizer, and the new value shows at most four clock cycles after the edge.
- R4: With `res_sel` = 7, the counter advances by one at each clock edge where `sw_step` is 1. In every other code, `sw_step` leaves `tag_value` unchanged.
- R5: When `host_wr` is 1, the next clock edge sets `tag_value` to `host_wdata`. A sync event or an increment in the same cycle is discarded.
- R6: When `sync_clr` is 1 and `clr_on_sync` is 1, the next edge sets `tag_value` to 0000. When `clr_on_sync` is 0, `sync_clr` leaves the value unchanged.
- R7: When `sync_load` is 1 and `load_on_sync` is 1, the next edge sets `tag_value` to `sync_data`. When `load_on_sync` is 0, `sync_load` leaves the value unchanged. An enabled load beats an enabled clear in the same cycle.
- R8: `rollover` is 1 for exactly one cycle, in the cycle in which `tag_value` first reads 0000 after an increment from FFFF. A host write or sync load of 0000 does not raise it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| res_sel | input | 3 | Source/resolution code: 0-5 internal (2-64 µs), 6 external clock, 7 software step |
| ext_clk | input | 1 | External increment clock, asynchronous |
| sw_step | input | 1 | Software increment strobe, one step per high cycle |
| clr_on_sync | input | 1 | Enable clearing on a Synchronize without data |
| load_on_sync | input | 1 | Enable loading on a Synchronize with data |
| sync_clr | input | 1 | One-cycle event: Synchronize without data received |
| sync_load | input | 1 | One-cycle event: Synchronize with data received |
| sync_data | input | 16 | Data word of the Synchronize with data command |
| host_wr | input | 1 | Host write strobe |
| host_wdata | input | 16 | Host write value |
| tag_value | output | 16 | Current counter value |
| rollover | output | 1 | One-cycle pulse on wrap from FFFF to 0000 |

## Verification
A wrong source state, or a time base that does not restart, shows at the ports as a count that has drifted by the next tick. The bench samples half a tick period away from each expected step. A broken priority between write, load, clear and increment shows in `tag_value` one cycle after the colliding inputs. A misplaced `rollover` shows in the same cycle as the wrap, since the pulse must line up with the 0000 reading.

// File: rtl/tt_pkg.sv
package tt_pkg;
    localparam int TAG_W = 16;
    localparam int RES_W = 3;
    localparam int DIV_W = 6;

    typedef enum logic [1:0] {
        SRC_TIMER  = 2'd0,
        SRC_EXTERN = 2'd1,
        SRC_STROBE = 2'd2
    } src_state_t;

    localparam logic [RES_W-1:0] CODE_EXTERN = 3'd6;
    localparam logic [RES_W-1:0] CODE_STROBE = 3'd7;
endpackage

// File: rtl/tt_tick_gen.sv
module tt_tick_gen
    import tt_pkg::*;
#(
    parameter int CLK_PER_US = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic [RES_W-1:0] res_sel,
    output logic             tick
);
    localparam int US_W = (CLK_PER_US > 1) ? $clog2(CLK_PER_US) : 1;
    localparam logic [US_W-1:0] US_LAST = US_W'(CLK_PER_US - 1);

    logic [US_W-1:0]  us_cnt;
    logic [DIV_W-1:0] div_cnt;
    logic [DIV_W-1:0] div_last;
    logic             us_tick;

    // period in microseconds is 2^(code+1); last count is one less
    always_comb begin
        div_last = DIV_W'((7'd2 << res_sel) - 7'd1);
        us_tick  = (us_cnt == US_LAST);
        tick     = us_tick && (div_cnt == div_last);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            us_cnt  <= '0;
            div_cnt <= '0;
        end else if (restart) begin
            us_cnt  <= '0;
            div_cnt <= '0;
        end else begin
            us_cnt <= us_tick ? '0 : us_cnt + 1'b1;
            if (us_tick) begin
                div_cnt <= (div_cnt == div_last) ? '0 : div_cnt + 1'b1;
            end
        end
    end

    // R2
    tick_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
endmodule

// File: rtl/tt_ext_edge.sv
module tt_ext_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic ext_clk,
    output logic ext_rise
);
    logic meta_q, sync_q, prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= 1'b0;
            sync_q <= 1'b0;
            prev_q <= 1'b0;
        end else begin
            meta_q <= ext_clk;
            sync_q <= meta_q;
            prev_q <= sync_q;
        end
    end

    assign ext_rise = sync_q & ~prev_q;

    // R3
    ext_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ext_rise |=> !ext_rise);
endmodule

// File: rtl/tt_src_fsm.sv
module tt_src_fsm
    import tt_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [RES_W-1:0] res_sel,
    input  logic             timer_tick,
    input  logic             ext_rise,
    input  logic             sw_step,
    output logic             restart,
    output logic             inc
);
    src_state_t       state_q, state_d;
    logic [RES_W-1:0] code_q;

    always_comb begin
        unique case (res_sel)
            CODE_EXTERN: state_d = SRC_EXTERN;
            CODE_STROBE: state_d = SRC_STROBE;
            default:     state_d = SRC_TIMER;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SRC_TIMER;
            code_q  <= '0;
        end else begin
            state_q <= state_d;
            code_q  <= res_sel;
        end
    end

    always_comb begin
        restart = (res_sel != code_q);
        unique case (state_q)
            SRC_TIMER:  inc = timer_tick;
            SRC_EXTERN: inc = ext_rise;
            SRC_STROBE: inc = sw_step;
            default:    inc = 1'b0;
        endcase
    end

    // R4
    strobe_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != SRC_STROBE && sw_step && !timer_tick && !ext_rise) |-> !inc);
endmodule

// File: rtl/time_tag_counter.sv
module time_tag_counter
    import tt_pkg::*;
#(
    parameter int CLK_PER_US = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [2:0]  res_sel,
    input  logic        ext_clk,
    input  logic        sw_step,
    input  logic        clr_on_sync,
    input  logic        load_on_sync,
    input  logic        sync_clr,
    input  logic        sync_load,
    input  logic [15:0] sync_data,
    input  logic        host_wr,
    input  logic [15:0] host_wdata,
    output logic [15:0] tag_value,
    output logic        rollover
);
    logic             timer_tick, ext_rise, restart, inc;
    logic             load_hit, clr_hit;
    logic [TAG_W-1:0] cnt_q;
    logic             roll_q;

    tt_src_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .res_sel    (res_sel),
        .timer_tick (timer_tick),
        .ext_rise   (ext_rise),
        .sw_step    (sw_step),
        .restart    (restart),
        .inc        (inc)
    );

    tt_tick_gen #(.CLK_PER_US(CLK_PER_US)) u_tick (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (restart),
        .res_sel (res_sel),
        .tick    (timer_tick)
    );

    tt_ext_edge u_ext (
        .clk      (clk),
        .rst_n    (rst_n),
        .ext_clk  (ext_clk),
        .ext_rise (ext_rise)
    );

    assign load_hit = sync_load & load_on_sync;
    assign clr_hit  = sync_clr & clr_on_sync;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            roll_q <= 1'b0;
        end else begin
            roll_q <= 1'b0;
            if (host_wr) begin
                cnt_q <= host_wdata;
            end else if (load_hit) begin
                cnt_q <= sync_data;
            end else if (clr_hit) begin
                cnt_q <= '0;
            end else if (inc) begin
                cnt_q  <= cnt_q + 1'b1;
                roll_q <= &cnt_q;
            end
        end
    end

    assign tag_value = cnt_q;
    assign rollover  = roll_q;

    // R5
    host_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        host_wr |=> (tag_value == $past(host_wdata)));
    // R8
    roll_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rollover |-> (tag_value == 16'h0000));
    // R8
    roll_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rollover |=> !rollover);
    // R2
    step_size_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!host_wr && !load_hit && !clr_hit) |=>
        (tag_value == $past(tag_value) || tag_value == $past(tag_value) + 16'd1));
endmodule

// File: tb/sim_time_tag_counter.sv
module sim_time_tag_counter;
    localparam int P = 4;
    localparam int NV = 6;
    localparam logic [2:0] VCODE [NV] = '{3'd0, 3'd1, 3'd2, 3'd3, 3'd4, 3'd5};
    localparam int         VSTEP [NV] = '{5, 3, 2, 2, 1, 1};

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  res_sel = 3'd0;
    logic        ext_clk = 1'b0, sw_step = 1'b0;
    logic        clr_on_sync = 1'b0, load_on_sync = 1'b0;
    logic        sync_clr = 1'b0, sync_load = 1'b0;
    logic [15:0] sync_data = '0, host_wdata = '0;
    logic        host_wr = 1'b0;
    logic [15:0] tag_value;
    logic        rollover;

    int n_chk = 0, n_bad = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    time_tag_counter #(.CLK_PER_US(P)) u0 (.*);

    task automatic check(string req, logic [15:0] act, logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset(logic [2:0] code);
        @(negedge clk);
        rst_n = 1'b0;
        res_sel = code;
        cyc(2);
        rst_n = 1'b1;
    endtask

    task automatic host_write(logic [15:0] v);
        host_wr = 1'b1; host_wdata = v;
        cyc(1);
        host_wr = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        // R1 reset state
        cyc(2);
        check("R1 tag", tag_value, 16'h0000);
        check("R1 roll", {15'd0, rollover}, 16'h0000);
        rst_n = 1'b1;
        cyc(1);
        check("R1 after release", tag_value, 16'h0000);

        // R2 resolution vectors: sample half a tick period past n ticks
        for (int i = 0; i < NV; i++) begin
            int per;
            per = P * (2 << VCODE[i]);
            do_reset(VCODE[i]);
            cyc(VSTEP[i] * per + per / 2);
            check("R2 resolution", tag_value, 16'(VSTEP[i]));
        end

        // R3 external clock: 3 rising edges
        do_reset(3'd6);
        cyc(3);
        for (int k = 0; k < 3; k++) begin
            ext_clk = 1'b1; cyc(6);
            ext_clk = 1'b0; cyc(6);
        end
        check("R3 ext edges", tag_value, 16'd3);

        // R4 sw_step ignored in external mode
        sw_step = 1'b1; cyc(3); sw_step = 1'b0; cyc(1);
        check("R4 step ignored", tag_value, 16'd3);

        // R4 software step mode
        res_sel = 3'd7; cyc(3);
        sw_step = 1'b1; cyc(2); sw_step = 1'b0; cyc(1);
        check("R4 step count", tag_value, 16'd5);

        // R5 write beats step in same cycle
        host_wr = 1'b1; host_wdata = 16'h1234; sw_step = 1'b1;
        cyc(1);
        host_wr = 1'b0; sw_step = 1'b0;
        check("R5 write priority", tag_value, 16'h1234);

        // R6 clear disabled then enabled
        sync_clr = 1'b1; cyc(1); sync_clr = 1'b0;
        check("R6 clear disabled", tag_value, 16'h1234);
        clr_on_sync = 1'b1;
        sync_clr = 1'b1; cyc(1); sync_clr = 1'b0;
        check("R6 clear enabled", tag_value, 16'h0000);

        // R7 load disabled, enabled, and beating clear
        sync_data = 16'hA5C3;
        sync_load = 1'b1; cyc(1); sync_load = 1'b0;
        check("R7 load disabled", tag_value, 16'h0000);
        load_on_sync = 1'b1;
        sync_load = 1'b1; sync_clr = 1'b1; cyc(1);
        sync_load = 1'b0; sync_clr = 1'b0;
        check("R7 load over clear", tag_value, 16'hA5C3);

        // R8 rollover on increment from FFFF
        host_write(16'hFFFF);
        check("R8 no pulse on write", {15'd0, rollover}, 16'h0000);
        sw_step = 1'b1; cyc(1); sw_step = 1'b0;
        check("R8 wrap value", tag_value, 16'h0000);
        check("R8 pulse", {15'd0, rollover}, 16'h0001);
        cyc(1);
        check("R8 pulse width", {15'd0, rollover}, 16'h0000);

        // R8 load of zero gives no pulse
        sync_data = 16'h0000;
        host_write(16'h0005);
        sync_load = 1'b1; cyc(1); sync_load = 1'b0;
        check("R8 load zero", {15'd0, rollover}, 16'h0000);

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule